// File: doc/BRIEF.md
# Paired-Block Interrupt Status and Vector Unit

This unit gathers the interrupt events of a four-block, eight-channel serial card and turns them into two host interrupt lines. Every block owns an 8-bit status register fed by its two channels and an 8-bit mask written by the host. Line 0 serves blocks 0 and 1, and line 1 serves blocks 2 and 3. A line is high while either of its blocks has a status bit whose mask bit is also set.

The host reaches the unit over a small request/response stream. A request carries a space code, an 8-bit address, a write flag and write data. A request moves when `req_valid` and `req_ready` are both high at a clock edge. Every accepted read returns exactly one response word on `resp_valid`/`resp_data`, starting in the next cycle. Writes return nothing. While a response waits with `resp_ready` low, `req_ready` is low and the response word does not change, so the host controls the pace.

Besides the status and mask registers, the unit holds an 8-bit interrupt vector. The host reads the vector back through the acknowledge space, and it can also read a 12-byte identification ROM.

Top module: `irq_vec_unit`

## Requirements
- R1: After reset, every status register, every mask and the vector are 0, both interrupt lines are low, `resp_valid` is low and `req_ready` is high.
- R2: A high bit of `evt_set` (block b, bit k at index 8b+k) sets that status bit at the next edge, and a high bit of `evt_clr` clears it. When both are high, the bit ends set. Status bit layout: 0/1/2 = transmit-ready, receive-ready and break of the even channel; 3 = counter ready; 4/5/6 = transmit-ready, receive-ready and break of the odd channel; 7 = input change.
- R3: The status/mask offset 0x0B reads the block's status and writes the block's mask. Writing the mask never changes what a read of that offset returns.
- R4: In the I/O space (space code 0), the block is addr[7:5] and the register offset is addr[4:0] XOR 1. Block numbers 4 to 7 are unpopulated: their reads return 0 and their writes change nothing. Offsets the unit does not own read 0.
- R5: Line n (`irq_o[n]`) is the OR, over blocks 2n and 2n+1, of any bit of (status AND mask). It takes its new value one clock after the status or mask change.
- R6: An I/O write to command offset 0x05 or 0x15 with write data bits [7:4] equal to 5 clears status bits 2 and 6 of the addressed block only. Other bits and other blocks keep their values, and any other command value leaves status unchanged.
- R7: A write to address 1 of the ID space (code 1) or the memory space (code 3) loads the vector. Writes to any other address in those spaces are ignored.
- R8: A read of acknowledge-space (code 2) address 0 or 2 returns the vector. Any other address there reads 0.
- R9: An ID-space read returns ROM byte addr>>1 from the list 49 50 41 43 F0 22 A1 00 00 00 0C CC (hex, index 0 first). Indices from 12 upward read 0.
- R10: Every memory-space read returns 0.
- R11: `req_ready` equals NOT `resp_valid` OR `resp_ready`. A stalled response keeps its data. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Unit can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_space | input | 2 | 0 I/O, 1 ID, 2 acknowledge, 3 memory |
| req_addr | input | 8 | Byte address within the space |
| req_wdata | input | 8 | Write data |
| resp_valid | output | 1 | Read data present |
| resp_ready | input | 1 | Host takes read data |
| resp_data | output | 8 | Read data |
| evt_set | input | 32 | Per-block status set pulses, index 8b+k |
| evt_clr | input | 32 | Per-block status clear pulses, index 8b+k |
| irq_o | output | 2 | Interrupt lines |

## Verification
The hardest case to reach is the stall. A second request must sit on the bus while an earlier response waits. The stimulus holds `resp_ready` low after a ROM read and presents another ROM read for several cycles, checking that neither the ready nor the held data moves. It then releases the stall and checks that the two responses arrive in order. A second hard case is a write to an unpopulated block that aliases block 0 in the low address bits. It is exposed because block 0 has a pending status bit masked off, so an aliased mask write would raise line 0.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  typedef enum logic [1:0] {
    SP_IO  = 2'd0,
    SP_ID  = 2'd1,
    SP_ACK = 2'd2,
    SP_MEM = 2'd3
  } space_e;

  localparam int          ROM_LEN       = 12;
  localparam logic [4:0]  OFF_STAT_MASK = 5'h0B;
  localparam logic [4:0]  OFF_CMD_EVEN  = 5'h05;
  localparam logic [4:0]  OFF_CMD_ODD   = 5'h15;
  localparam logic [3:0]  CMD_CLR_BRK   = 4'd5;
  localparam logic [7:0]  BRK_BITS      = 8'h44;

  function automatic logic [7:0] rom_byte(input logic [6:0] idx);
    logic [7:0] b;
    case (idx)
      7'd0:    b = 8'h49;
      7'd1:    b = 8'h50;
      7'd2:    b = 8'h41;
      7'd3:    b = 8'h43;
      7'd4:    b = 8'hF0;
      7'd5:    b = 8'h22;
      7'd6:    b = 8'hA1;
      7'd10:   b = 8'h0C;
      7'd11:   b = 8'hCC;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/ivu_decode.sv
module ivu_decode
  import irq_vec_pkg::*;
#(
  parameter int NBLK = 4
) (
  input  logic            fire,
  input  logic            we,
  input  space_e          space,
  input  logic [7:0]      addr,
  input  logic [3:0]      cmd,
  output logic [2:0]      blk_sel,
  output logic            blk_ok,
  output logic            stat_hit,
  output logic [NBLK-1:0] imr_wr,
  output logic [NBLK-1:0] brk_clr,
  output logic            vec_wr
);
  logic [4:0] off;
  logic       io_wr;
  logic       cmd_hit;

  assign blk_sel  = addr[7:5];
  assign off      = addr[4:0] ^ 5'h01;
  assign blk_ok   = int'(blk_sel) < NBLK;
  assign stat_hit = (space == SP_IO) && blk_ok && (off == OFF_STAT_MASK);
  assign io_wr    = fire && we && (space == SP_IO) && blk_ok;
  assign cmd_hit  = ((off == OFF_CMD_EVEN) || (off == OFF_CMD_ODD)) && (cmd == CMD_CLR_BRK);
  assign vec_wr   = fire && we && ((space == SP_ID) || (space == SP_MEM)) && (addr == 8'd1);

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    assign imr_wr[b]  = io_wr && (int'(blk_sel) == b) && (off == OFF_STAT_MASK);
    assign brk_clr[b] = io_wr && (int'(blk_sel) == b) && cmd_hit;
  end

endmodule

// File: rtl/ivu_isr_bank.sv
module ivu_isr_bank
  import irq_vec_pkg::*;
#(
  parameter int NBLK = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBLK*8-1:0] evt_set,
  input  logic [NBLK*8-1:0] evt_clr,
  input  logic [NBLK-1:0]   brk_clr,
  input  logic [NBLK-1:0]   imr_wr,
  input  logic [7:0]        wdata,
  output logic [NBLK*8-1:0] isr_flat,
  output logic [NBLK*8-1:0] imr_flat
);

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    logic [7:0] isr_q, imr_q, clr_mask;

    assign clr_mask = evt_clr[8*b +: 8] | (brk_clr[b] ? BRK_BITS : 8'h00);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        isr_q <= '0;
        imr_q <= '0;
      end else begin
        isr_q <= (isr_q & ~clr_mask) | evt_set[8*b +: 8];
        if (imr_wr[b]) imr_q <= wdata;
      end
    end

    assign isr_flat[8*b +: 8] = isr_q;
    assign imr_flat[8*b +: 8] = imr_q;
  end

endmodule

// File: rtl/ivu_line_or.sv
module ivu_line_or #(
  parameter int NBLK  = 4,
  parameter int NLINE = (NBLK + 1) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBLK*8-1:0] isr_flat,
  input  logic [NBLK*8-1:0] imr_flat,
  output logic [NLINE-1:0]  irq_q
);
  logic [NBLK-1:0] blk_pend;

  for (genvar b = 0; b < NBLK; b++) begin : g_pend
    assign blk_pend[b] = |(isr_flat[8*b +: 8] & imr_flat[8*b +: 8]);
  end

  for (genvar n = 0; n < NLINE; n++) begin : g_line
    logic pend_n;
    if (2 * n + 1 < NBLK) begin : g_pair
      assign pend_n = blk_pend[2*n] | blk_pend[2*n+1];
    end else begin : g_single
      assign pend_n = blk_pend[2*n];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) irq_q[n] <= 1'b0;
      else        irq_q[n] <= pend_n;
    end
  end

endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit
  import irq_vec_pkg::*;
#(
  parameter int NBLK  = 4,
  parameter int NLINE = (NBLK + 1) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [1:0]        req_space,
  input  logic [7:0]        req_addr,
  input  logic [7:0]        req_wdata,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [7:0]        resp_data,
  input  logic [NBLK*8-1:0] evt_set,
  input  logic [NBLK*8-1:0] evt_clr,
  output logic [NLINE-1:0]  irq_o
);
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1;

  logic              fire;
  space_e            space;
  logic [2:0]        blk_sel;
  logic              blk_ok, stat_hit, vec_wr;
  logic [NBLK-1:0]   imr_wr, brk_clr;
  logic [NBLK*8-1:0] isr_flat, imr_flat;
  logic [7:0]        isr_arr [NBLK];
  logic [7:0]        vec_q;
  logic [7:0]        rd_val;

  assign space     = space_e'(req_space);
  assign req_ready = !resp_valid || resp_ready;
  assign fire      = req_valid && req_ready;

  ivu_decode #(.NBLK(NBLK)) dec_i (
    .fire(fire), .we(req_we), .space(space), .addr(req_addr),
    .cmd(req_wdata[7:4]), .blk_sel(blk_sel), .blk_ok(blk_ok),
    .stat_hit(stat_hit), .imr_wr(imr_wr), .brk_clr(brk_clr), .vec_wr(vec_wr)
  );

  ivu_isr_bank #(.NBLK(NBLK)) bank_i (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .evt_clr(evt_clr),
    .brk_clr(brk_clr), .imr_wr(imr_wr), .wdata(req_wdata),
    .isr_flat(isr_flat), .imr_flat(imr_flat)
  );

  ivu_line_or #(.NBLK(NBLK), .NLINE(NLINE)) lines_i (
    .clk(clk), .rst_n(rst_n), .isr_flat(isr_flat), .imr_flat(imr_flat),
    .irq_q(irq_o)
  );

  for (genvar b = 0; b < NBLK; b++) begin : g_arr
    assign isr_arr[b] = isr_flat[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_wr) vec_q <= req_wdata;
  end

  always_comb begin
    rd_val = 8'h00;
    case (space)
      SP_IO:   if (stat_hit && blk_ok) rd_val = isr_arr[blk_sel[BW-1:0]];
      SP_ID:   rd_val = rom_byte(req_addr[7:1]);
      SP_ACK:  if ((req_addr == 8'd0) || (req_addr == 8'd2)) rd_val = vec_q;
      default: rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else if (fire && !req_we) begin
      resp_valid <= 1'b1;
      resp_data  <= rd_val;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/ivu_chk.sv
module ivu_chk #(
  parameter int NBLK  = 4,
  parameter int NLINE = (NBLK + 1) / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic [7:0]        resp_data,
  input logic [NLINE-1:0]  irq_o,
  input logic [NBLK*8-1:0] isr_flat,
  input logic [NBLK*8-1:0] imr_flat,
  input logic [NBLK*8-1:0] evt_set,
  input logic [NBLK-1:0]   brk_clr,
  input logic [7:0]        vec_q,
  input logic              vec_wr
);

  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (vec_q == 8'h00 && irq_o == '0 && !resp_valid && isr_flat == '0));

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((isr_flat[8*b +: 8] & $past(evt_set[8*b +: 8])) == $past(evt_set[8*b +: 8])));

    p_brk_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_clr[b] && !evt_set[8*b+2] && !evt_set[8*b+6])
        |=> (isr_flat[8*b+2] == 1'b0 && isr_flat[8*b+6] == 1'b0));
  end

  for (genvar n = 0; n < NLINE; n++) begin : g_line
    if (2 * n + 1 < NBLK) begin : g_pair
      p_line_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o[n] == $past((|(isr_flat[16*n +: 8] & imr_flat[16*n +: 8])) ||
                                     (|(isr_flat[16*n+8 +: 8] & imr_flat[16*n+8 +: 8])))));
    end
  end

  p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_wr |=> $stable(vec_q));

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));

  p_stall_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |-> !req_ready);

endmodule

bind irq_vec_unit ivu_chk #(.NBLK(NBLK), .NLINE(NLINE)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
  .resp_ready(resp_ready), .resp_data(resp_data), .irq_o(irq_o),
  .isr_flat(isr_flat), .imr_flat(imr_flat), .evt_set(evt_set),
  .brk_clr(brk_clr), .vec_q(vec_q), .vec_wr(vec_wr)
);

// File: tb/irq_vec_unit_tb_top.sv
module irq_vec_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NBLK = 4;
  localparam int NLINE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, resp_ready = 1'b1;
  logic [1:0] req_space = 2'd0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic req_ready, resp_valid;
  logic [7:0] resp_data;
  logic [NBLK*8-1:0] evt_set = '0, evt_clr = '0;
  logic [NLINE-1:0] irq_o;

  int n_checks = 0;
  int n_fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  irq_vec_unit #(.NBLK(NBLK), .NLINE(NLINE)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_space(req_space), .req_addr(req_addr),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_data(resp_data), .evt_set(evt_set), .evt_clr(evt_clr), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Monitor: sampled after the bench's drives, before the next rising edge.
  always begin
    @(negedge clk);
    #2;
    if (resp_valid && resp_ready) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fails++;
        $display("FAIL R11: actual unexpected response %02h expected none", resp_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, resp_data, e);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic bus_write(logic [1:0] sp, logic [7:0] a, logic [7:0] d);
    tick();
    req_valid = 1'b1; req_we = 1'b1; req_space = sp; req_addr = a; req_wdata = d;
    tick();
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] sp, logic [7:0] a, logic [7:0] e, string tag);
    tick();
    exp_q.push_back(e); tag_q.push_back(tag);
    req_valid = 1'b1; req_we = 1'b0; req_space = sp; req_addr = a;
    tick();
    req_valid = 1'b0;
  endtask

  task automatic pulse(logic [NBLK*8-1:0] s, logic [NBLK*8-1:0] c);
    tick();
    evt_set = s; evt_clr = c;
    tick();
    evt_set = '0; evt_clr = '0;
  endtask

  logic [7:0] rom_exp [12] = '{8'h49, 8'h50, 8'h41, 8'h43, 8'hF0, 8'h22,
                               8'hA1, 8'h00, 8'h00, 8'h00, 8'h0C, 8'hCC};

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 irq", {6'b0, irq_o}, 8'h00);
    check("R1 resp_valid", {7'b0, resp_valid}, 8'h00);
    check("R1 req_ready", {7'b0, req_ready}, 8'h01);
    bus_read(2'd0, 8'h0A, 8'h00, "R1 status blk0");
    bus_read(2'd2, 8'h00, 8'h00, "R1 vector");

    // R2 set/clear, R4 decode
    pulse(32'h0000_1002, '0);
    bus_read(2'd0, 8'h0A, 8'h02, "R2 status blk0");
    bus_read(2'd0, 8'h2A, 8'h10, "R2 status blk1");
    bus_read(2'd0, 8'h6A, 8'h00, "R2 status blk3");
    bus_read(2'd0, 8'h0B, 8'h00, "R4 offset xor");
    pulse(32'h0000_0001, 32'h0000_0003);
    bus_read(2'd0, 8'h0A, 8'h01, "R2 set wins");
    bus_write(2'd0, 8'h2A, 8'h00);
    pulse('0, 32'h0000_FF00);
    bus_read(2'd0, 8'h2A, 8'h00, "R2 clear blk1");

    // R3 / R5 masks and line timing
    check("R5 masked off", {6'b0, irq_o}, 8'h00);
    bus_write(2'd0, 8'h0A, 8'h01);
    check("R5 one cycle latency", {6'b0, irq_o}, 8'h00);
    tick();
    check("R5 line0 up", {6'b0, irq_o}, 8'h01);
    bus_read(2'd0, 8'h0A, 8'h01, "R3 read gives status");
    bus_write(2'd0, 8'h0A, 8'h80);
    tick();
    check("R5 line0 down", {6'b0, irq_o}, 8'h00);
    pulse(32'h4000_0000, '0);
    bus_write(2'd0, 8'h6A, 8'h44);
    tick();
    check("R5 line1 up", {6'b0, irq_o}, 8'h02);

    // R6 break clear command
    pulse(32'h0504_0000, '0);
    bus_write(2'd0, 8'h64, 8'h40);
    bus_read(2'd0, 8'h6A, 8'h45, "R6 other cmd ignored");
    bus_write(2'd0, 8'h74, 8'h5F);
    bus_read(2'd0, 8'h6A, 8'h01, "R6 breaks cleared");
    bus_read(2'd0, 8'h4A, 8'h04, "R6 other block kept");
    tick();
    check("R5 line1 down after R6", {6'b0, irq_o}, 8'h00);

    // R4 unpopulated block aliasing block 0
    bus_write(2'd0, 8'h8A, 8'hFF);
    tick(); tick();
    check("R4 unpopulated write", {6'b0, irq_o}, 8'h00);
    bus_read(2'd0, 8'h8A, 8'h00, "R4 unpopulated read");
    bus_read(2'd0, 8'hEA, 8'h00, "R4 block7 read");
    bus_read(2'd0, 8'h04, 8'h00, "R4 unowned offset");

    // R7 / R8 vector
    bus_write(2'd1, 8'h01, 8'hA5);
    bus_read(2'd2, 8'h00, 8'hA5, "R8 ack line0");
    bus_read(2'd2, 8'h02, 8'hA5, "R8 ack line1");
    bus_read(2'd2, 8'h01, 8'h00, "R8 ack other");
    bus_read(2'd2, 8'h04, 8'h00, "R8 ack addr4");
    bus_write(2'd1, 8'h03, 8'h11);
    bus_read(2'd2, 8'h00, 8'hA5, "R7 id write ignored");
    bus_write(2'd3, 8'h01, 8'h3C);
    bus_read(2'd2, 8'h02, 8'h3C, "R7 mem write");
    bus_write(2'd3, 8'h00, 8'h77);
    bus_read(2'd2, 8'h00, 8'h3C, "R7 mem write ignored");

    // R9 ROM
    for (int a = 0; a < 24; a++)
      bus_read(2'd1, 8'(a), rom_exp[a/2], $sformatf("R9 rom addr %0d", a));
    bus_read(2'd1, 8'd24, 8'h00, "R9 past end");
    bus_read(2'd1, 8'hFF, 8'h00, "R9 top addr");

    // R10 memory reads
    bus_read(2'd3, 8'h01, 8'h00, "R10 mem addr1");
    bus_read(2'd3, 8'h00, 8'h00, "R10 mem addr0");

    // R11 back-pressure
    tick();
    resp_ready = 1'b0;
    bus_read(2'd1, 8'h00, 8'h49, "R11 first stalled");
    check("R11 ready low", {7'b0, req_ready}, 8'h00);
    check("R11 data held", resp_data, 8'h49);
    exp_q.push_back(8'h41); tag_q.push_back("R11 second after stall");
    req_valid = 1'b1; req_we = 1'b0; req_space = 2'd1; req_addr = 8'h04;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R11 ready stays low", {7'b0, req_ready}, 8'h00);
      check("R11 data stable", resp_data, 8'h49);
    end
    resp_ready = 1'b1;
    tick();
    req_valid = 1'b0;
    repeat (4) tick();
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fails++;
      $display("FAIL R11: actual %0d responses missing expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule